// File: doc/BRIEF.md
# Serial Security Register Program Engine

This block is the target-side command path that programs one of three small one-time-programmable security registers in a serial flash. It watches a single-bit SPI link. The link carries a chip-select, a serial clock and a data-in line. The engine recognises the program opcode, collects a 24-bit address and then takes any number of data bytes. Two things gate the command: the write-enable latch, and a sticky lock bit for each register. The data bytes go into a staging buffer first. The engine merges that buffer into the addressed register only after chip-select rises on a clean byte boundary.

All three registers sit in one flip-flop memory that is written through a single port. After reset the block walks that memory and sets every byte to the erased value 0xFF. Programming can only move a bit from 1 to 0, because each staged byte is ANDed into the stored byte. While the engine merges or erases it raises a busy flag. When a real program finishes it pulses a one-cycle request to clear the write-enable latch, which lives elsewhere. A separate read port with one cycle of latency lets the surrounding read logic see the stored bytes.

The SPI pins are synchronised into the system clock domain. Bits are taken on the rising serial clock edge, so both idle-low and idle-high clock conventions work.

Top module: `secreg_prog_engine`

## Requirements
- R1: While reset is high and for exactly 3*2^OFS_W clock cycles after it is released, `busy` is 1. After that, every byte of all three registers reads 0xFF. `wel_clr` stays 0 through this erase.
- R2: A command is recognised only when the first byte after chip-select falls is 0x42, sent MSB first and sampled on rising serial clock edges. The serial clock may idle low (mode 0) or high (mode 3). Any other first byte makes the whole transfer have no effect.
- R3: The command has no effect if `wel` is 0 when the opcode byte completes.
- R4: The three address bytes follow MSB first. Address bits [15:12] = 1, 2 or 3 select register 1, 2 or 3. Bits [23:16] and [11:8] must be zero, or the command has no effect; any other value in [15:12] also makes it have no effect. Bits [OFS_W-1:0] give the starting offset, and bits [7:OFS_W] are ignored.
- R5: `lock[0]`, `lock[1]` and `lock[2]` protect registers 1, 2 and 3. A command aimed at a register whose lock bit is 1 when the address completes has no effect. Registers that are not locked can still be programmed.
- R6: A committed command changes each stored byte to (old AND new). Offsets that received no data byte keep their value.
- R7: The offset increments after every data byte and wraps from 2^OFS_W-1 to 0 inside the same register. If an offset is written more than once in one command, the last byte sent to it is the one merged.
- R8: The merge happens only if chip-select rises after at least one complete data byte and with no partial byte pending. A transfer that ends mid-byte, or ends right after the address, has no effect.
- R9: After a commit `busy` is 1 for exactly 2^OFS_W cycles. `wel_clr` is 1 for the single cycle in which `busy` first reads 0 again.
- R10: A transfer whose chip-select falls while `busy` is 1 has no effect.
- R11: `rd_data` shows the byte at (`rd_sel`, `rd_ofs`) one clock after they are applied, with `rd_sel` 1..3 naming the register. For `rd_sel` 0 or 3'd... any value outside 1..3 (that is, 0), `rd_data` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI serial data in |
| wel | input | 1 | Write-enable latch state |
| lock | input | 3 | Lock bits for registers 3..1 (bit 0 = register 1) |
| rd_sel | input | 2 | Register to read (1..3) |
| rd_ofs | input | OFS_W | Byte offset to read |
| rd_data | output | 8 | Read data, one cycle after the request |
| busy | output | 1 | Erase or merge in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The bench builds the engine with OFS_W = 4, so each register holds 16 bytes and the erase walk takes 48 cycles. At this size a sweep over every starting offset of every register is cheap. Transfer lengths run from 1 to 20 bytes, so offset wrap and over-length overwrite happen many times. After every command all 48 bytes are compared against an arithmetic model. A second pass starts from an erased array and sends all-zero data, so any command that is wrongly accepted shows up at once. That pass covers the rejection cases: the write-enable gate, a wrong opcode, each bad address field, lock bits, partial and empty data, and a start during busy.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam logic [7:0] PROG_OPCODE = 8'h42;
  localparam int         NREG        = 3;
  localparam logic [7:0] ERASED      = 8'hFF;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_OPCODE,
    CS_ADDR,
    CS_DATA,
    CS_SKIP
  } cmd_state_e;
endpackage

// File: rtl/secreg_spi_rx.sv
module secreg_spi_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       frm_start,
  output logic       frm_end,
  output logic       frm_aligned,
  output logic       byte_vld,
  output logic [7:0] byte_data
);
  logic [1:0] cs_sy, sclk_sy, mosi_sy;
  logic       cs_d, sclk_d;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       sclk_rise;

  assign sclk_rise = sclk_sy[1] & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sy       <= 2'b11;
      sclk_sy     <= 2'b00;
      mosi_sy     <= 2'b00;
      cs_d        <= 1'b1;
      sclk_d      <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      frm_start   <= 1'b0;
      frm_end     <= 1'b0;
      frm_aligned <= 1'b0;
      byte_vld    <= 1'b0;
      byte_data   <= '0;
    end else begin
      cs_sy       <= {cs_sy[0], cs_n};
      sclk_sy     <= {sclk_sy[0], sclk};
      mosi_sy     <= {mosi_sy[0], mosi};
      cs_d        <= cs_sy[1];
      sclk_d      <= sclk_sy[1];
      frm_start   <= cs_d & ~cs_sy[1];
      frm_end     <= ~cs_d & cs_sy[1];
      frm_aligned <= (bit_cnt == 3'd0);
      byte_vld    <= 1'b0;
      if (cs_sy[1]) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg   <= {shreg[5:0], mosi_sy[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, mosi_sy[1]};
        end
      end
    end
  end

  p_byte_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> !cs_d);
  p_start_end_apart_r8: assert property (@(posedge clk) disable iff (rst)
    frm_start |-> !frm_end);
endmodule

// File: rtl/secreg_cmd_fsm.sv
module secreg_cmd_fsm
  import secreg_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             frm_aligned,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             wel,
  input  logic [2:0]       lock,
  input  logic             busy,
  output logic             stg_clr,
  output logic             stg_we,
  output logic [OFS_W-1:0] stg_ofs,
  output logic [7:0]       stg_data,
  output logic             commit,
  output logic [1:0]       commit_sel
);
  cmd_state_e       state;
  logic [1:0]       addr_cnt;
  logic [15:0]      addr_hi;
  logic [23:0]      addr_full;
  logic [3:0]       nib;
  logic             lock_hit, addr_ok, seen_data;
  logic [OFS_W-1:0] ofs;

  assign addr_full = {addr_hi, byte_data};
  assign nib       = addr_full[15:12];
  assign lock_hit  = (nib == 4'd1 && lock[0]) || (nib == 4'd2 && lock[1]) ||
                     (nib == 4'd3 && lock[2]);
  assign addr_ok   = (addr_full[23:16] == 8'h00) && (addr_full[11:8] == 4'h0) &&
                     (nib >= 4'd1) && (nib <= 4'd3) && !lock_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CS_IDLE;
      addr_cnt   <= '0;
      addr_hi    <= '0;
      seen_data  <= 1'b0;
      ofs        <= '0;
      stg_clr    <= 1'b0;
      stg_we     <= 1'b0;
      stg_ofs    <= '0;
      stg_data   <= '0;
      commit     <= 1'b0;
      commit_sel <= '0;
    end else begin
      stg_clr <= 1'b0;
      stg_we  <= 1'b0;
      commit  <= 1'b0;
      if (frm_start) begin
        seen_data <= 1'b0;
        addr_cnt  <= '0;
        if (busy) begin
          state <= CS_SKIP;
        end else begin
          state   <= CS_OPCODE;
          stg_clr <= 1'b1;
        end
      end else if (frm_end) begin
        if (state == CS_DATA && seen_data && frm_aligned) commit <= 1'b1;
        state <= CS_IDLE;
      end else if (byte_vld) begin
        case (state)
          CS_OPCODE: state <= (byte_data == PROG_OPCODE && wel) ? CS_ADDR : CS_SKIP;
          CS_ADDR: begin
            addr_hi  <= addr_full[15:0];
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == 2'd2) begin
              if (addr_ok) begin
                state      <= CS_DATA;
                commit_sel <= nib[1:0] - 2'd1;
                ofs        <= addr_full[OFS_W-1:0];
              end else begin
                state <= CS_SKIP;
              end
            end
          end
          CS_DATA: begin
            stg_we    <= 1'b1;
            stg_ofs   <= ofs;
            stg_data  <= byte_data;
            ofs       <= ofs + 1'b1;
            seen_data <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_commit_on_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(frm_end && frm_aligned));
  p_commit_sel_valid_r4: assert property (@(posedge clk) disable iff (rst)
    commit |-> commit_sel != 2'd3);
  p_stage_quiet_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (stg_we || stg_clr) |-> !busy);
endmodule

// File: rtl/secreg_store.sv
module secreg_store
  import secreg_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stg_clr,
  input  logic             stg_we,
  input  logic [OFS_W-1:0] stg_ofs,
  input  logic [7:0]       stg_data,
  input  logic             commit,
  input  logic [1:0]       commit_sel,
  input  logic [1:0]       rd_sel,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             wel_clr
);
  localparam int DEPTH  = 1 << OFS_W;
  localparam int NBYTES = NREG * DEPTH;
  localparam int AW     = OFS_W + 2;

  logic [7:0]       stage [DEPTH];
  logic [7:0]       mem   [NBYTES];
  logic             erasing;
  logic [AW-1:0]    wcnt, wlast, mem_wa;
  logic [1:0]       psel;
  logic [OFS_W-1:0] widx;
  logic [7:0]       mem_wd;

  assign widx   = wcnt[OFS_W-1:0];
  assign wlast  = erasing ? AW'(NBYTES - 1) : AW'(DEPTH - 1);
  assign mem_wa = erasing ? wcnt : {psel, widx};
  assign mem_wd = erasing ? ERASED : (mem[mem_wa] & stage[widx]);

  always_ff @(posedge clk) begin
    if (stg_clr) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= ERASED;
    end else if (stg_we) begin
      stage[stg_ofs] <= stg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (busy) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b1;
      erasing <= 1'b1;
      wcnt    <= '0;
      psel    <= '0;
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      if (commit) begin
        busy    <= 1'b1;
        erasing <= 1'b0;
        wcnt    <= '0;
        psel    <= commit_sel;
      end else if (busy) begin
        if (wcnt == wlast) begin
          busy    <= 1'b0;
          wel_clr <= !erasing;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= ERASED;
    else if (rd_sel == 2'd0) rd_data <= ERASED;
    else rd_data <= mem[{rd_sel - 2'd1, rd_ofs}];
  end

  p_no_commit_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
    commit |-> !busy);
  p_welclr_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    wel_clr |-> (!busy && $past(busy)));
  p_welclr_single_r9: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !wel_clr);
  p_commit_starts_busy_r9: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy);
endmodule

// File: rtl/secreg_prog_engine.sv
module secreg_prog_engine #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  input  logic             wel,
  input  logic [2:0]       lock,
  input  logic [1:0]       rd_sel,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             wel_clr
);
  logic             frm_start, frm_end, frm_aligned, byte_vld;
  logic [7:0]       byte_data;
  logic             stg_clr, stg_we, commit;
  logic [OFS_W-1:0] stg_ofs;
  logic [7:0]       stg_data;
  logic [1:0]       commit_sel;

  secreg_spi_rx u_rx (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .frm_start(frm_start), .frm_end(frm_end), .frm_aligned(frm_aligned),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  secreg_cmd_fsm #(.OFS_W(OFS_W)) u_fsm (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
    .frm_aligned(frm_aligned), .byte_vld(byte_vld), .byte_data(byte_data),
    .wel(wel), .lock(lock), .busy(busy), .stg_clr(stg_clr), .stg_we(stg_we),
    .stg_ofs(stg_ofs), .stg_data(stg_data), .commit(commit), .commit_sel(commit_sel)
  );

  secreg_store #(.OFS_W(OFS_W)) u_store (
    .clk(clk), .rst(rst), .stg_clr(stg_clr), .stg_we(stg_we), .stg_ofs(stg_ofs),
    .stg_data(stg_data), .commit(commit), .commit_sel(commit_sel),
    .rd_sel(rd_sel), .rd_ofs(rd_ofs), .rd_data(rd_data), .busy(busy), .wel_clr(wel_clr)
  );
endmodule

// File: tb/sim_secreg_prog_engine.sv
module sim_secreg_prog_engine;
  localparam int OW   = 4;
  localparam int D    = 1 << OW;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, cs_n, sclk, mosi, wel;
  logic [2:0]    lock;
  logic [1:0]    rd_sel;
  logic [OW-1:0] rd_ofs;
  logic [7:0]    rd_data;
  logic          busy, wel_clr;

  secreg_prog_engine #(.OFS_W(OW)) u0 (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .wel(wel), .lock(lock), .rd_sel(rd_sel), .rd_ofs(rd_ofs), .rd_data(rd_data),
    .busy(busy), .wel_clr(wel_clr)
  );

  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 0;
  logic [7:0] model [3][D];
  logic [7:0] tx [64];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(bit b, bit m3);
    if (m3) sclk = 1'b0;
    mosi = b;
    clks(HALF);
    sclk = 1'b1;
    clks(HALF);
    if (!m3) sclk = 1'b0;
  endtask

  task automatic spi_byte(logic [7:0] b, bit m3);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], m3);
  endtask

  task automatic xfer(logic [7:0] opc, logic [23:0] adr, int nb, int extra, bit m3);
    sclk = m3;
    clks(2);
    cs_n = 1'b0;
    clks(HALF);
    spi_byte(opc, m3);
    spi_byte(adr[23:16], m3);
    spi_byte(adr[15:8], m3);
    spi_byte(adr[7:0], m3);
    for (int k = 0; k < nb; k++) spi_byte(tx[k], m3);
    for (int k = 0; k < extra; k++) spi_bit(1'b1, m3);
    clks(HALF);
    cs_n = 1'b1;
    clks(2);
  endtask

  task automatic expect_busy(bit exp, string req);
    int w = 0;
    int n = 0;
    while (!busy && w < 12) begin
      clks(1);
      w++;
    end
    if (!exp) begin
      chk({req, " no busy (R9)"}, busy, 0);
    end else begin
      chk("R9 busy raised", busy, 1);
      while (busy && n < 4 * D) begin
        n++;
        clks(1);
      end
      chk("R9 busy length", n, D);
      chk("R9 wel_clr at end", wel_clr, 1);
      clks(1);
      chk("R9 wel_clr one cycle", wel_clr, 0);
    end
  endtask

  task automatic verify_all(string req);
    for (int s = 1; s <= 3; s++) begin
      for (int o = 0; o < D; o++) begin
        rd_sel = 2'(s);
        rd_ofs = OW'(o);
        clks(1);
        chk({req, " R11 read"}, rd_data, model[s-1][o]);
      end
    end
  endtask

  function automatic bit accepted(logic [7:0] opc, logic [23:0] adr, int nb, int extra,
                                  bit welv, logic [2:0] lockv);
    int nib = int'(adr[15:12]);
    if (opc != 8'h42 || !welv) return 0;
    if (adr[23:16] != 8'h00 || adr[11:8] != 4'h0) return 0;
    if (nib < 1 || nib > 3) return 0;
    if (lockv[nib-1]) return 0;
    if (nb < 1 || extra != 0) return 0;
    return 1;
  endfunction

  task automatic apply_model(logic [23:0] adr, int nb);
    logic [7:0] st [D];
    int o = int'(adr[OW-1:0]);
    int r = int'(adr[15:12]) - 1;
    for (int i = 0; i < D; i++) st[i] = 8'hFF;
    for (int k = 0; k < nb; k++) begin
      st[o] = tx[k];
      o = (o + 1) % D;
    end
    for (int i = 0; i < D; i++) model[r][i] = model[r][i] & st[i];
  endtask

  task automatic run(logic [7:0] opc, logic [23:0] adr, int nb, int extra, bit m3,
                     bit welv, logic [2:0] lockv, string req);
    bit ok;
    wel  = welv;
    lock = lockv;
    xfer(opc, adr, nb, extra, m3);
    ok = accepted(opc, adr, nb, extra, welv, lockv);
    if (ok) apply_model(adr, nb);
    expect_busy(ok, req);
    verify_all(req);
  endtask

  task automatic do_reset();
    int n = 0;
    bit saw = 0;
    rst = 1'b1;
    clks(3);
    rst = 1'b0;
    while (busy && n < 8 * D) begin
      if (wel_clr) saw = 1;
      n++;
      clks(1);
    end
    if (wel_clr) saw = 1;
    chk("R1 erase busy length", n, 3 * D);
    chk("R1 no wel_clr on erase", saw, 0);
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < D; o++) model[s][o] = 8'hFF;
    verify_all("R1 erased");
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    wel = 1'b1; lock = 3'b000; rd_sel = 2'd0; rd_ofs = '0;
    clks(2);
    do_reset();

    rd_sel = 2'd0;
    rd_ofs = OW'(5);
    clks(1);
    chk("R11 rd_sel 0", rd_data, 8'hFF);

    // sweep: every register, every start offset, lengths 1..20, both clock modes
    for (int r = 1; r <= 3; r++) begin
      for (int s = 0; s < D; s++) begin
        int nb = 1 + (s * 3 + r) % 20;
        for (int k = 0; k < nb; k++) begin
          if (s % 4 == 3) tx[k] = 8'((s * 16 + k * 7 + r * 3) ^ 8'hA5);
          else tx[k] = ~(8'd1 << ((s + k + r) % 8));
        end
        run(8'h42, {8'h00, 4'(r), 4'h0, 4'h0, 4'(s)}, nb, 0, s[0], 1'b1, 3'b000,
            (nb > D) ? "R7 R2 sweep" : "R6 R2 sweep");
      end
    end

    do_reset();
    for (int k = 0; k < 64; k++) tx[k] = 8'h00;

    run(8'h42, 24'h001003, 2, 0, 1'b0, 1'b0, 3'b000, "R3 wel low");
    run(8'h02, 24'h001003, 2, 0, 1'b0, 1'b1, 3'b000, "R2 wrong opcode");
    run(8'h43, 24'h002003, 2, 0, 1'b1, 1'b1, 3'b000, "R2 wrong opcode m3");
    run(8'h42, 24'h000004, 2, 0, 1'b0, 1'b1, 3'b000, "R4 nibble 0");
    run(8'h42, 24'h004004, 2, 0, 1'b0, 1'b1, 3'b000, "R4 nibble 4");
    run(8'h42, 24'h00F004, 2, 0, 1'b1, 1'b1, 3'b000, "R4 nibble F");
    run(8'h42, 24'h011004, 2, 0, 1'b0, 1'b1, 3'b000, "R4 high byte");
    run(8'h42, 24'h003104, 2, 0, 1'b0, 1'b1, 3'b000, "R4 mid nibble");
    run(8'h42, 24'h0020A5, 1, 0, 1'b0, 1'b1, 3'b000, "R4 upper offset bits ignored");
    run(8'h42, 24'h002008, 2, 0, 1'b0, 1'b1, 3'b010, "R5 reg2 locked");
    run(8'h42, 24'h001008, 1, 0, 1'b1, 1'b1, 3'b010, "R5 reg1 open");
    run(8'h42, 24'h003008, 1, 0, 1'b0, 1'b1, 3'b010, "R5 reg3 open");
    run(8'h42, 24'h00100C, 1, 0, 1'b0, 1'b1, 3'b101, "R5 reg1 locked");
    run(8'h42, 24'h00300C, 1, 0, 1'b1, 1'b1, 3'b101, "R5 reg3 locked");
    run(8'h42, 24'h00100E, 2, 3, 1'b0, 1'b1, 3'b000, "R8 partial byte");
    run(8'h42, 24'h00200E, 1, 7, 1'b1, 1'b1, 3'b000, "R8 seven extra bits");
    run(8'h42, 24'h00300E, 0, 0, 1'b0, 1'b1, 3'b000, "R8 no data");
    run(8'h42, 24'h00300E, 0, 5, 1'b0, 1'b1, 3'b000, "R8 partial first byte");

    // R10: second transfer starts while the first merge is running
    wel = 1'b1;
    lock = 3'b000;
    xfer(8'h42, 24'h001001, 1, 0, 1'b0);
    apply_model(24'h001001, 1);
    begin
      int w = 0;
      while (!busy && w < 12) begin
        clks(1);
        w++;
      end
    end
    chk("R10 first merge busy", busy, 1);
    xfer(8'h42, 24'h001006, 3, 0, 1'b0);
    expect_busy(1'b0, "R10 start during busy");
    verify_all("R10 start during busy");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule